// File: doc/BRIEF.md
# Frame Timestamp Snapshot Array

This block keeps a time-of-arrival snapshot for each of several network ports. Each port sends a one-cycle strobe when a start-of-frame delimiter goes past. The unit copies the shared free-running time value into that port's snapshot register in the same clock cycle. A message classifier sends a second strobe later, once it knows what the frame was. That strobe carries a message kind and a good/bad verdict. If the frame is the kind of timing message that matters for the port's role, the snapshot freezes. It then stays held until software releases it.

Software reaches every channel through a plain word-wide register port. Each channel has a window of 32 bytes. The window holds a configuration word, a status word and the two halves of the snapshot. The configuration word has three controls:

- a role bit, where 1 is time master and 0 is slave;
- a capture-every-frame bit, which disables freezing;
- a self-clearing-by-software channel reset.

No data path here carries back-pressure. The event strobes carry no ready signal. Each one is acted on in the cycle it is high, so the sender must not expect it to be held or retried. Register reads return data in the same cycle, and a write takes effect on the clock edge where it is presented.

Top module: `tsu_snap_array`

## Requirements
- R1: After the reset input, every channel reads back a configuration word of 0 (slave role, freezing enabled, channel reset off), a snapshot of 0 and a cleared held flag.
- R2: When a channel is not held and not in channel reset, an SFD strobe copies `time_now` of that same cycle into the snapshot. The new value is visible from the next cycle.
- R3: With capture-every-frame off, a classification with `cls_good`=1 freezes the snapshot and raises the held flag. This happens only when an SFD was captured since the last classification or release, and only when the kind matches the role. Kind code 0 (Sync) matches master role (config bit 0 = 1), and kind code 1 (Delay Request) matches slave role (config bit 0 = 0).
- R4: A classification that is bad, or whose kind does not match the role (kind codes 2 and 3 never match), leaves the held flag clear and keeps the captured value.
- R5: While a channel is held, further SFD strobes and classifications leave its snapshot unchanged.
- R6: Status bit 0 reads 1 while a snapshot is held. Writing 1 to it releases the hold. Writing 0 has no effect.
- R7: When config bit 1 (capture every frame) is set, the channel never holds. Every SFD overwrites the snapshot, and setting the bit drops any existing hold within two cycles.
- R8: Writing config bit 2 = 1 forces the role and capture-every-frame bits to 0 and clears the snapshot and held flag. The configuration reads 0x4, and SFDs, classifications and releases are ignored until a later config write with bit 2 = 0.
- R9: Channel c occupies byte addresses 0x40 + 0x20·c onward. The offsets are +0x0 config (bits 2:0), +0x4 status (bit 0), +0x8 snapshot bits 31:0 and +0xC snapshot bits 63:32. Any other address reads 0, and activity on one channel never alters another.
- R10: If a qualifying classification and a new SFD arrive in the same cycle, the hold wins and the snapshot keeps the earlier frame's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | TS_W | Shared free-running time value |
| sfd_pulse | input | NUM_CH | Per-channel start-of-frame strobe |
| cls_valid | input | NUM_CH | Per-channel classification strobe |
| cls_good | input | NUM_CH | Classification verdict, 1 = valid message |
| cls_kind | input | 2*NUM_CH | Message kind per channel, 2 bits each (0 Sync, 1 Delay Request, 2/3 other) |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| snap_value | output | TS_W*NUM_CH | Snapshot of each channel, channel c at bits c*TS_W upward |
| snap_held | output | NUM_CH | Held flag of each channel |

## Verification
The bench builds the array with two channels, a 64-bit time value and a 12-bit address. With two channels, the channel-select field is a single address bit, and the first unused window directly above the array can be probed. That size also makes it cheap to sweep both channels through every combination of role, message kind and verdict, with the expected hold computed from the role-match rule. The same setup reaches the ordering corner cases: a lock and a capture in the same cycle, a release during a hold, capture-every-frame taking over a held channel, and strobes arriving during a channel reset.

// File: rtl/tsu_pkg.sv
package tsu_pkg;

  typedef enum logic [1:0] {
    MSG_SYNC    = 2'd0,
    MSG_DLY_REQ = 2'd1,
    MSG_FOLLOW  = 2'd2,
    MSG_DLY_RSP = 2'd3
  } msg_kind_e;

  // packed so that bit 2 = channel reset, bit 1 = capture all, bit 0 = master
  typedef struct packed {
    logic hold_rst;
    logic stamp_all;
    logic is_master;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    WORD_CFG   = 2'd0,
    WORD_STAT  = 2'd1,
    WORD_SNAPL = 2'd2,
    WORD_SNAPH = 2'd3
  } reg_word_e;

  function automatic logic kind_qualifies(input logic is_master, input logic [1:0] kind);
    if (is_master) return kind == MSG_SYNC;
    return kind == MSG_DLY_REQ;
  endfunction

endpackage

// File: rtl/tsu_chan_cfg.sv
module tsu_chan_cfg
  import tsu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       stat_we,
  input  logic [2:0] wbits,
  output chan_cfg_t  cfg_q,
  output logic       release_req
);

  chan_cfg_t cfg_next;

  always_comb begin
    cfg_next = cfg_q;
    if (cfg_we) begin
      if (wbits[2]) begin
        cfg_next.hold_rst  = 1'b1;
        cfg_next.stamp_all = 1'b0;
        cfg_next.is_master = 1'b0;
      end else begin
        cfg_next.hold_rst  = 1'b0;
        cfg_next.stamp_all = wbits[1];
        cfg_next.is_master = wbits[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_next;
  end

  // release acts on the same edge as the status write; ignored in channel reset
  assign release_req = stat_we && wbits[0] && !cfg_q.hold_rst;

endmodule

// File: rtl/tsu_snap_core.sv
module tsu_snap_core
  import tsu_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  chan_cfg_t       cfg,
  input  logic            release_req,
  input  logic            sfd,
  input  logic            cls_valid,
  input  logic            cls_good,
  input  logic [1:0]      cls_kind,
  input  logic [TS_W-1:0] time_now,
  output logic [TS_W-1:0] snap_q,
  output logic            held_q
);

  logic pend_q;
  logic lock_evt;

  assign lock_evt = !cfg.stamp_all && !held_q && pend_q && cls_valid && cls_good &&
                    kind_qualifies(cfg.is_master, cls_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      held_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (cfg.hold_rst) begin
      snap_q <= '0;
      held_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (held_q) begin
      if (release_req || cfg.stamp_all) begin
        held_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end else if (cfg.stamp_all) begin
      pend_q <= 1'b0;
      if (sfd) snap_q <= time_now;
    end else if (lock_evt) begin
      held_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (cls_valid) pend_q <= 1'b0;
      if (sfd) begin
        snap_q <= time_now;
        pend_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tsu_reg_decode.sv
module tsu_reg_decode
  import tsu_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter int BASE   = 64,
  parameter int STRIDE = 32,
  parameter int TS_W   = 64
) (
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [2:0]              wbits,
  input  chan_cfg_t               cfg_q   [NUM_CH],
  input  logic [NUM_CH-1:0]       held,
  input  logic [TS_W*NUM_CH-1:0]  snaps,
  output logic [NUM_CH-1:0]       cfg_we,
  output logic [NUM_CH-1:0]       stat_we,
  output logic [31:0]             reg_rdata
);

  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int OFS_W = $clog2(STRIDE);
  localparam int WRD_W = OFS_W - 2;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE + NUM_CH * STRIDE);

  logic [ADDR_W-1:0] rel;
  logic              hit;
  logic [CH_W-1:0]   chan;
  logic [WRD_W-1:0]  word_idx;
  logic              word_ok;
  logic [1:0]        word;
  logic [63:0]       sel_snap;
  logic              dec_unused;

  assign rel      = reg_addr - ADDR_W'(BASE);
  assign hit      = ({1'b0, reg_addr} >= WIN_LO) && ({1'b0, reg_addr} < WIN_HI);
  assign chan     = rel[OFS_W +: CH_W];
  assign word_idx = rel[OFS_W-1:2];
  assign word_ok  = int'(word_idx) < 4;
  assign word     = word_idx[1:0];
  assign dec_unused = ^{rel[1:0], rel[ADDR_W-1:OFS_W+CH_W]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
    logic sel;
    assign sel        = reg_we && hit && word_ok && (int'(chan) == c);
    assign cfg_we[c]  = sel && (word == WORD_CFG);
    assign stat_we[c] = sel && (word == WORD_STAT);
  end

  always_comb begin
    sel_snap  = '0;
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(chan) == c) sel_snap = 64'(snaps[c*TS_W +: TS_W]);
    end
    if (hit && word_ok) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (int'(chan) == c) begin
          case (word)
            WORD_CFG:   reg_rdata = {29'd0, cfg_q[c]};
            WORD_STAT:  reg_rdata = {31'd0, held[c]};
            WORD_SNAPL: reg_rdata = sel_snap[31:0];
            default:    reg_rdata = sel_snap[63:32];
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/tsu_snap_array.sv
module tsu_snap_array
  import tsu_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 12,
  parameter int BASE   = 64,
  parameter int STRIDE = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        time_now,
  input  logic [NUM_CH-1:0]      sfd_pulse,
  input  logic [NUM_CH-1:0]      cls_valid,
  input  logic [NUM_CH-1:0]      cls_good,
  input  logic [2*NUM_CH-1:0]    cls_kind,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [TS_W*NUM_CH-1:0] snap_value,
  output logic [NUM_CH-1:0]      snap_held
);

  chan_cfg_t          cfg_q [NUM_CH];
  logic [NUM_CH-1:0]  cfg_we;
  logic [NUM_CH-1:0]  stat_we;
  logic [NUM_CH-1:0]  rel_req;
  logic [NUM_CH-1:0]  chan_crst;
  logic [NUM_CH-1:0]  chan_all;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata[31:3];

  tsu_reg_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .TS_W(TS_W)
  ) u_dec (
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wbits    (reg_wdata[2:0]),
    .cfg_q    (cfg_q),
    .held     (snap_held),
    .snaps    (snap_value),
    .cfg_we   (cfg_we),
    .stat_we  (stat_we),
    .reg_rdata(reg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tsu_chan_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we[c]),
      .stat_we    (stat_we[c]),
      .wbits      (reg_wdata[2:0]),
      .cfg_q      (cfg_q[c]),
      .release_req(rel_req[c])
    );

    assign chan_crst[c] = cfg_q[c].hold_rst;
    assign chan_all[c]  = cfg_q[c].stamp_all;

    tsu_snap_core #(.TS_W(TS_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg_q[c]),
      .release_req(rel_req[c]),
      .sfd        (sfd_pulse[c]),
      .cls_valid  (cls_valid[c]),
      .cls_good   (cls_good[c]),
      .cls_kind   (cls_kind[2*c +: 2]),
      .time_now   (time_now),
      .snap_q     (snap_value[c*TS_W +: TS_W]),
      .held_q     (snap_held[c])
    );
  end

endmodule

// File: rtl/tsu_snap_chk.sv
module tsu_snap_chk #(
  parameter int NUM_CH = 8,
  parameter int TS_W   = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH-1:0]      cls_valid,
  input logic [NUM_CH-1:0]      cls_good,
  input logic [TS_W*NUM_CH-1:0] snap_value,
  input logic [NUM_CH-1:0]      snap_held,
  input logic [NUM_CH-1:0]      chan_crst,
  input logic [NUM_CH-1:0]      chan_all
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_p
    // R3
    lock_needs_good_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!snap_held[c] && !(cls_valid[c] && cls_good[c])) |=> !snap_held[c]);

    // R5
    held_value_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_held[c] && !chan_crst[c]) |=> $stable(snap_value[c*TS_W +: TS_W]));

    // R7
    stamp_all_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_all[c] |=> !snap_held[c]);

    // R8
    chan_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_crst[c] |=> (!snap_held[c] && snap_value[c*TS_W +: TS_W] == '0));
  end

endmodule

bind tsu_snap_array tsu_snap_chk #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cls_valid (cls_valid),
  .cls_good  (cls_good),
  .snap_value(snap_value),
  .snap_held (snap_held),
  .chan_crst (chan_crst),
  .chan_all  (chan_all)
);

// File: tb/tb_tsu_snap_array.sv
module tb_tsu_snap_array;
  localparam int NCH = 2;
  localparam int TSW = 64;
  localparam int AW  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [TSW-1:0]    time_now = '0;
  logic [NCH-1:0]    sfd_pulse = '0;
  logic [NCH-1:0]    cls_valid = '0;
  logic [NCH-1:0]    cls_good = '0;
  logic [2*NCH-1:0]  cls_kind = '0;
  logic              reg_we = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [TSW*NCH-1:0] snap_value;
  logic [NCH-1:0]    snap_held;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] tval = 64'hA5A5_0000_FFFF_FFF0;

  always #5 clk = ~clk;

  tsu_snap_array #(.NUM_CH(NCH), .TS_W(TSW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .sfd_pulse(sfd_pulse),
    .cls_valid(cls_valid), .cls_good(cls_good), .cls_kind(cls_kind),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .snap_value(snap_value), .snap_held(snap_held)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] adr(input int ch, input int word);
    return AW'(64 + ch * 32 + word * 4);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] snap_of(input int ch);
    return snap_value[ch*TSW +: TSW];
  endfunction

  function automatic logic [63:0] next_time();
    tval = tval + 64'h0000_0001_0000_0013;
    return tval;
  endfunction

  // SFD in one cycle, classification in the next
  task automatic frame(input int ch, input logic [1:0] kind, input logic good,
                       input logic [63:0] t);
    time_now = t;
    sfd_pulse[ch] = 1'b1;
    tick();
    sfd_pulse[ch] = 1'b0;
    cls_valid[ch] = 1'b1;
    cls_good[ch] = good;
    cls_kind[2*ch +: 2] = kind;
    tick();
    cls_valid[ch] = 1'b0;
    cls_good[ch] = 1'b0;
  endtask

  task automatic snap_regs(input int ch, input logic [63:0] exp, input string req);
    logic [31:0] lo, hi;
    rd(adr(ch, 2), lo);
    rd(adr(ch, 3), hi);
    chk(req, {hi, lo}, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, t2, last0;
    bit exp_lock;
    last0 = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int ch = 0; ch < NCH; ch++) begin
      rd(adr(ch, 0), d); chk("R1 cfg", 64'(d), 64'd0);
      chk("R1 snap", snap_of(ch), 64'd0);
      chk("R1 held", 64'(snap_held[ch]), 64'd0);
    end

    // R2 R3 R4 sweep: channel x role x kind x verdict
    for (int ch = 0; ch < NCH; ch++) begin
      for (int role = 0; role < 2; role++) begin
        wr(adr(ch, 0), 32'(role));
        for (int k = 0; k < 4; k++) begin
          for (int g = 0; g < 2; g++) begin
            t = next_time();
            frame(ch, 2'(k), g[0], t);
            exp_lock = (g == 1) && ((role == 1) ? (k == 0) : (k == 1));
            chk(exp_lock ? "R3 held" : "R4 not held", 64'(snap_held[ch]), 64'(exp_lock));
            chk("R2 capture", snap_of(ch), t);
            if (ch == 0) last0 = t;
            if (exp_lock) begin
              rd(adr(ch, 1), d); chk("R6 status reads held", 64'(d), 64'd1);
              wr(adr(ch, 1), 32'd1);
              chk("R6 release", 64'(snap_held[ch]), 64'd0);
            end
          end
        end
      end
    end
    // R9 channel 1 activity left channel 0 alone; register halves
    chk("R9 isolation", snap_of(0), last0);
    snap_regs(0, last0, "R9 snap regs ch0");
    snap_regs(1, t, "R9 snap regs ch1");
    rd(adr(1, 0), d); chk("R9 cfg ch1", 64'(d), 64'd1);
    rd(AW'(64 + NCH * 32), d); chk("R9 above window", 64'(d), 64'd0);
    rd(AW'(12'h03C), d); chk("R9 below window", 64'(d), 64'd0);
    rd(adr(0, 4), d); chk("R9 unused word", 64'(d), 64'd0);

    // R5 held value survives later frames
    wr(adr(0, 0), 32'd0);
    t = next_time();
    frame(0, 2'd1, 1'b1, t);
    chk("R5 locked", 64'(snap_held[0]), 64'd1);
    t2 = next_time();
    frame(0, 2'd1, 1'b1, t2);
    chk("R5 snap frozen", snap_of(0), t);
    chk("R5 still held", 64'(snap_held[0]), 64'd1);
    // R6 writing 0 does nothing
    wr(adr(0, 1), 32'd0);
    chk("R6 zero write", 64'(snap_held[0]), 64'd1);
    wr(adr(0, 1), 32'd1);
    chk("R6 one write", 64'(snap_held[0]), 64'd0);

    // R10 qualifying classification with simultaneous SFD
    t = next_time();
    time_now = t; sfd_pulse[0] = 1'b1; tick();
    t2 = next_time();
    time_now = t2; cls_valid[0] = 1'b1; cls_good[0] = 1'b1; cls_kind[1:0] = 2'd1;
    tick();
    sfd_pulse[0] = 1'b0; cls_valid[0] = 1'b0; cls_good[0] = 1'b0;
    chk("R10 held", 64'(snap_held[0]), 64'd1);
    chk("R10 earlier value", snap_of(0), t);

    // R7 capture-every-frame drops the hold and never holds
    wr(adr(0, 0), 32'd2);
    tick();
    chk("R7 drop hold", 64'(snap_held[0]), 64'd0);
    for (int i = 0; i < 3; i++) begin
      t = next_time();
      frame(0, 2'd1, 1'b1, t);
      chk("R7 no hold", 64'(snap_held[0]), 64'd0);
      chk("R7 overwrite", snap_of(0), t);
    end

    // R8 channel reset
    wr(adr(0, 0), 32'd1);
    t = next_time();
    frame(0, 2'd0, 1'b1, t);
    chk("R8 pre held", 64'(snap_held[0]), 64'd1);
    wr(adr(0, 0), 32'd7);
    rd(adr(0, 0), d); chk("R8 cfg reads 4", 64'(d), 64'd4);
    tick();
    chk("R8 held cleared", 64'(snap_held[0]), 64'd0);
    chk("R8 snap cleared", snap_of(0), 64'd0);
    t = next_time();
    frame(0, 2'd1, 1'b1, t);
    chk("R8 sfd ignored", snap_of(0), 64'd0);
    chk("R8 no hold", 64'(snap_held[0]), 64'd0);
    wr(adr(0, 0), 32'd0);
    rd(adr(0, 0), d); chk("R8 released cfg", 64'(d), 64'd0);
    t = next_time();
    frame(0, 2'd1, 1'b1, t);
    chk("R8 works after", snap_of(0), t);
    chk("R8 holds after", 64'(snap_held[0]), 64'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule